// File: doc/BRIEF.md
# Asynchronous SRAM Bus Controller

This block sits on the synchronous side of a chip and runs an external 16-bit asynchronous static RAM built from two 8-bit halves. A host presents a single-cycle request carrying an address, write data, a write flag and a width flag. The controller latches it and plays out the strobe sequence the memory needs. Each phase lasts a whole number of controller clocks, found by rounding the memory's nanosecond minimums up to clock periods. When the access is over it raises a one-clock done pulse, which also carries the read data for a read.

The two halves have separate chip-select and write-enable lines and share one output-enable line. In word mode both halves take part in every access. In byte mode the host address gains one extra low bit. That bit picks the half, the remaining bits form the memory address, and only the chosen half's chip select (and write enable, for a write) is driven. A byte read returns the selected byte zero-extended. The data bus leaves the block as a value plus a drive enable, so the tri-state buffer sits in the pad ring.

Top module: `sram_bus_ctrl`

## Requirements
- R1: While reset is held and just after it, all chip selects and write enables are high (inactive), output enable is high, the bus drive enable is low, and done and busy are low.
- R2: A word read holds both chip selects low, output enable low and both write enables high for RD_CYC clocks. RD_CYC is the ceiling of the largest of read-cycle, address-access and enable-to-data time over the clock period: 7 at the defaults (35 ns, 5 ns clock). The input bus sampled in the last of those clocks is presented on rdata during the done clock that follows.
- R3: A write holds the selected chip selects and write enables low, with output enable high, for WP_CYC clocks. WP_CYC is the ceiling of the larger of write-pulse and data-setup time: 5 at the defaults. The bus drive enable is high with the write data for exactly those clocks.
- R4: After the write pulse, all strobes stay inactive for REC_CYC clocks before done. REC_CYC is the write-cycle count minus WP_CYC, at least 1: 2 at the defaults. A write is therefore busy for 7 clocks at the defaults.
- R5: The bus drive enable is never high while output enable is low, and output enable never falls in the clock right after the drive enable was high.
- R6: In byte mode, host address bit 0 equal to 0 selects the low half (strobe index 0, data bits 7:0), and 1 selects the high half (index 1, bits 15:8). The memory address is host address bits AW:1, and only the selected half's chip select and write enable go low.
- R7: A byte write puts the host's low data byte on both halves of the output bus.
- R8: A byte read returns the selected half's byte in rdata bits 7:0, with bits 15:8 zero.
- R9: In word mode, the memory address is host address bits AW-1:0, and the top host address bit has no effect.
- R10: done is high for exactly one clock per accepted request. busy is high from the clock after acceptance until the done clock, in which it is low.
- R11: A request presented while busy is high is ignored: it produces no access and no done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request strobe, accepted when busy is low |
| req_write | input | 1 | 1 = write, 0 = read |
| req_byte | input | 1 | 1 = byte access, 0 = word access |
| req_addr | input | AW+1 | Host address; bit 0 picks the half in byte mode |
| req_wdata | input | 16 | Write data (bits 7:0 used in byte mode) |
| busy | output | 1 | An access is in progress |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 16 | Read data, valid with done |
| sram_addr | output | AW | Memory address |
| sram_cs_n | output | 2 | Chip selects per half, active low |
| sram_we_n | output | 2 | Write enables per half, active low |
| sram_oe_n | output | 1 | Shared output enable, active low |
| sram_dq_out | output | 16 | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | 16 | Data from the memory |

## Verification
A phase counter that is off by one shows up at the strobe pins in the very access where it happens. The output-enable or write-enable low run comes out one clock short or long, and the busy run changes length with it. A wrong lane decision or a lost byte flag fires the wrong chip select in the first strobed clock, long before done. A read-capture fault shows only at the done pulse, as a wrong rdata value. A stuck acceptance path shows as a done with no matching request, or as a missing done the next time the bus is idle.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [1:0] {
    PH_IDLE    = 2'd0,
    PH_READ    = 2'd1,
    PH_WRITE   = 2'd2,
    PH_RECOVER = 2'd3
  } phase_e;

  // round a nanosecond minimum up to whole clock periods, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned t_ns,
                                            input int unsigned period_ps);
    int unsigned c;
    c = (t_ns * 1000 + period_ps - 1) / period_ps;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

  // recovery after the write pulse, at least one clock for bus turnaround
  function automatic int unsigned rec_cyc(input int unsigned wc, input int unsigned wp);
    return (wc > wp + 1) ? (wc - wp) : 1;
  endfunction

endpackage

// File: rtl/sram_phase_seq.sv
module sram_phase_seq
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned RD_CYC  = 7,
  parameter int unsigned WP_CYC  = 5,
  parameter int unsigned REC_CYC = 2
) (
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  logic   start_write,
  output phase_e phase,
  output logic   rd_capture,
  output logic   done
);

  localparam int unsigned MAXC = max2(max2(RD_CYC, WP_CYC), REC_CYC);
  localparam int unsigned CW   = $clog2(MAXC + 1);

  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero   = (cnt == '0);
  assign rd_capture = (phase == PH_READ) && cnt_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= PH_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (phase)
        PH_IDLE: begin
          if (start) begin
            phase <= start_write ? PH_WRITE : PH_READ;
            cnt   <= start_write ? CW'(WP_CYC - 1) : CW'(RD_CYC - 1);
          end
        end
        PH_READ: begin
          if (cnt_zero) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_WRITE: begin
          if (cnt_zero) begin
            phase <= PH_RECOVER;
            cnt   <= CW'(REC_CYC - 1);
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        PH_RECOVER: begin
          if (cnt_zero) begin
            phase <= PH_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  // R10
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R10
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> phase == PH_IDLE);

endmodule

// File: rtl/sram_lane_map.sv
module sram_lane_map #(
  parameter int unsigned AW     = 17,
  parameter int unsigned LANE_W = 8
) (
  input  logic [AW:0]         host_addr,
  input  logic                byte_mode,
  input  logic [2*LANE_W-1:0] host_wdata,
  input  logic [2*LANE_W-1:0] bus_in,
  output logic [AW-1:0]       mem_addr,
  output logic [1:0]          lane_en,
  output logic [2*LANE_W-1:0] bus_wdata,
  output logic [2*LANE_W-1:0] rd_word
);

  localparam int unsigned DW = 2 * LANE_W;

  logic half;
  assign half = host_addr[0];

  function automatic logic [AW-1:0] pick_addr(input logic [AW:0] a, input logic bm);
    return bm ? a[AW:1] : a[AW-1:0];
  endfunction

  function automatic logic [1:0] pick_lanes(input logic bm, input logic h);
    if (!bm) return 2'b11;
    return h ? 2'b10 : 2'b01;
  endfunction

  function automatic logic [DW-1:0] spread_byte(input logic [DW-1:0] w, input logic bm);
    return bm ? {w[LANE_W-1:0], w[LANE_W-1:0]} : w;
  endfunction

  function automatic logic [DW-1:0] shape_read(input logic [DW-1:0] w, input logic bm,
                                               input logic h);
    if (!bm) return w;
    return h ? {{LANE_W{1'b0}}, w[DW-1:LANE_W]} : {{LANE_W{1'b0}}, w[LANE_W-1:0]};
  endfunction

  assign mem_addr  = pick_addr(host_addr, byte_mode);
  assign lane_en   = pick_lanes(byte_mode, half);
  assign bus_wdata = spread_byte(host_wdata, byte_mode);
  assign rd_word   = shape_read(bus_in, byte_mode, half);

endmodule

// File: rtl/sram_strobe_gen.sv
module sram_strobe_gen
  import sram_ctrl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  phase_e     phase,
  input  logic [1:0] lane_en,
  output logic [1:0] cs_n,
  output logic [1:0] we_n,
  output logic       oe_n,
  output logic       dq_oe
);

  logic rd_active;
  logic wr_active;

  assign rd_active = (phase == PH_READ);
  assign wr_active = (phase == PH_WRITE);

  always_comb begin
    cs_n  = 2'b11;
    we_n  = 2'b11;
    oe_n  = 1'b1;
    dq_oe = 1'b0;
    if (rd_active) begin
      cs_n = ~lane_en;
      oe_n = 1'b0;
    end else if (wr_active) begin
      cs_n  = ~lane_en;
      we_n  = ~lane_en;
      dq_oe = 1'b1;
    end
  end

  // R5
  no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> oe_n);

  // R5
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(oe_n) |-> !$past(dq_oe));

  // R3
  we_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((~we_n & cs_n) == 2'b00) && (!(&we_n) -> oe_n));

endmodule

// File: rtl/sram_bus_ctrl.sv
module sram_bus_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW        = 17,
  parameter int unsigned LANE_W    = 8,
  parameter int unsigned CLK_PS    = 5000,
  parameter int unsigned T_RC_NS   = 35,
  parameter int unsigned T_AA_NS   = 35,
  parameter int unsigned T_OE_NS   = 20,
  parameter int unsigned T_WC_NS   = 35,
  parameter int unsigned T_WP_NS   = 25,
  parameter int unsigned T_DW_NS   = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic                req_byte,
  input  logic [AW:0]         req_addr,
  input  logic [2*LANE_W-1:0] req_wdata,
  output logic                busy,
  output logic                done,
  output logic [2*LANE_W-1:0] rdata,
  output logic [AW-1:0]       sram_addr,
  output logic [1:0]          sram_cs_n,
  output logic [1:0]          sram_we_n,
  output logic                sram_oe_n,
  output logic [2*LANE_W-1:0] sram_dq_out,
  output logic                sram_dq_oe,
  input  logic [2*LANE_W-1:0] sram_dq_in
);

  localparam int unsigned DW      = 2 * LANE_W;
  localparam int unsigned RD_CYC  = max2(ns_to_cyc(T_RC_NS, CLK_PS),
                                         max2(ns_to_cyc(T_AA_NS, CLK_PS),
                                              ns_to_cyc(T_OE_NS, CLK_PS)));
  localparam int unsigned WP_CYC  = max2(ns_to_cyc(T_WP_NS, CLK_PS),
                                         ns_to_cyc(T_DW_NS, CLK_PS));
  localparam int unsigned REC_CYC = rec_cyc(ns_to_cyc(T_WC_NS, CLK_PS), WP_CYC);

  phase_e         phase;
  logic           accept;
  logic           rd_capture;
  logic [AW:0]    addr_q;
  logic [DW-1:0]  wdata_q;
  logic           write_q;
  logic           byte_q;
  logic [1:0]     lane_en;
  logic [DW-1:0]  rd_word;

  assign busy   = (phase != PH_IDLE);
  assign accept = req_valid && !busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      write_q <= 1'b0;
      byte_q  <= 1'b0;
    end else if (accept) begin
      addr_q  <= req_addr;
      wdata_q <= req_wdata;
      write_q <= req_write;
      byte_q  <= req_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata <= '0;
    else if (rd_capture) rdata <= rd_word;
  end

  sram_phase_seq #(
    .RD_CYC (RD_CYC),
    .WP_CYC (WP_CYC),
    .REC_CYC(REC_CYC)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (accept),
    .start_write(req_write),
    .phase      (phase),
    .rd_capture (rd_capture),
    .done       (done)
  );

  sram_lane_map #(
    .AW    (AW),
    .LANE_W(LANE_W)
  ) u_map (
    .host_addr (addr_q),
    .byte_mode (byte_q),
    .host_wdata(wdata_q),
    .bus_in    (sram_dq_in),
    .mem_addr  (sram_addr),
    .lane_en   (lane_en),
    .bus_wdata (sram_dq_out),
    .rd_word   (rd_word)
  );

  sram_strobe_gen u_strb (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .lane_en(lane_en),
    .cs_n   (sram_cs_n),
    .we_n   (sram_we_n),
    .oe_n   (sram_oe_n),
    .dq_oe  (sram_dq_oe)
  );

  // run-length counter of write-enable low clocks, checker only
  logic [7:0] we_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           we_run <= '0;
    else if (&sram_we_n)  we_run <= '0;
    else                  we_run <= we_run + 1'b1;
  end

  // R3
  wp_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(&sram_we_n) |-> we_run == WP_CYC[7:0]);

  // R6
  byte_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_q && busy && !(&sram_cs_n)) |-> $countones(~sram_cs_n) == 1);

  // R8
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (done && byte_q && !write_q) |-> rdata[DW-1:LANE_W] == '0);

  // R11
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_valid) |=> ($stable(addr_q) && $stable(write_q) && $stable(byte_q)));

endmodule

// File: tb/sim_sram_bus_ctrl.sv
module sim_sram_bus_ctrl;

  localparam int AW = 17;
  // expected clock counts, 5 ns clock, restated as plain ceilings
  localparam int EXP_RD  = (35 + 4) / 5;
  localparam int EXP_WP  = ((25 > 20 ? 25 : 20) + 4) / 5;
  localparam int EXP_WBUSY = (35 + 4) / 5;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic          req_byte = 1'b0;
  logic [AW:0]   req_addr = '0;
  logic [15:0]   req_wdata = '0;
  logic          busy, done;
  logic [15:0]   rdata;
  logic [AW-1:0] sram_addr;
  logic [1:0]    sram_cs_n, sram_we_n;
  logic          sram_oe_n, sram_dq_oe;
  logic [15:0]   sram_dq_out, sram_dq_in;

  always #2.5 clk = ~clk;

  sram_bus_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_byte(req_byte), .req_addr(req_addr), .req_wdata(req_wdata),
    .busy(busy), .done(done), .rdata(rdata), .sram_addr(sram_addr),
    .sram_cs_n(sram_cs_n), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  int checks = 0;
  int fails  = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [15:0] seed_val(input logic [7:0] a);
    return {a ^ 8'hA5, a ^ 8'h3C};
  endfunction

  // behavioural memory, 256 words, indexed by the low address byte
  logic [15:0] mem [256];
  logic [15:0] shadow [256];
  initial for (int i = 0; i < 256; i++) begin
    mem[i] = seed_val(8'(i));
    shadow[i] = seed_val(8'(i));
  end

  always_comb begin
    for (int l = 0; l < 2; l++)
      sram_dq_in[l*8 +: 8] = (!sram_cs_n[l] && !sram_oe_n && sram_we_n[l])
                             ? mem[sram_addr[7:0]][l*8 +: 8] : 8'h00;
  end

  always @(posedge clk) begin
    for (int l = 0; l < 2; l++)
      if (!sram_cs_n[l] && !sram_we_n[l])
        mem[sram_addr[7:0]][l*8 +: 8] <= sram_dq_out[l*8 +: 8];
  end

  typedef struct {
    bit          wr;
    logic [16:0] addr;
    logic [1:0]  lanes;
    logic [15:0] bus;
    logic [15:0] rd;
  } item_t;

  item_t sbq[$];

  task automatic do_req(input bit wr, input bit bm, input logic [AW:0] a,
                        input logic [15:0] d);
    item_t it;
    logic [7:0] w;
    bit h;
    h = a[0];
    it.wr = wr;
    if (bm) begin
      it.addr  = a[AW:1];
      it.lanes = h ? 2'b10 : 2'b01;
      it.bus   = {d[7:0], d[7:0]};
    end else begin
      it.addr  = a[AW-1:0];
      it.lanes = 2'b11;
      it.bus   = d;
    end
    w = it.addr[7:0];
    if (wr) begin
      if (it.lanes[0]) shadow[w][7:0]  = it.bus[7:0];
      if (it.lanes[1]) shadow[w][15:8] = it.bus[15:8];
      it.rd = '0;
    end else if (bm) begin
      it.rd = h ? {8'h00, shadow[w][15:8]} : {8'h00, shadow[w][7:0]};
    end else begin
      it.rd = shadow[w];
    end
    @(negedge clk);
    while (busy) @(negedge clk);
    sbq.push_back(it);
    req_valid = 1'b1; req_write = wr; req_byte = bm; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: run lengths and first strobed clock, compared at done
  int busy_run = 0, we_run = 0, oe_run = 0;
  bit seen = 0;
  logic [16:0] obs_addr;
  logic [1:0]  obs_lanes;
  logic [15:0] obs_bus;
  bit          obs_oe;
  bit          prev_done = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (sram_dq_oe && !sram_oe_n)
        chk(0, "R5", "drive enable with output enable", 1, 0);
      if (busy) busy_run++;
      if (!(&sram_we_n)) we_run++;
      if (!sram_oe_n) oe_run++;
      if (!seen && !(&sram_cs_n)) begin
        seen = 1; obs_addr = sram_addr; obs_lanes = ~sram_cs_n;
        obs_bus = sram_dq_out; obs_oe = sram_dq_oe;
      end
      if (done) begin
        chk(!prev_done, "R10", "done width", 1, 0);
        chk(!busy, "R10", "busy during done", 32'(busy), 0);
        if (sbq.size() == 0) begin
          chk(0, "R11", "done without request", 1, 0);
        end else begin
          item_t it;
          it = sbq.pop_front();
          chk(obs_addr == it.addr, "R6/R9", "sram_addr", 32'(obs_addr), 32'(it.addr));
          chk(obs_lanes == it.lanes, "R6", "active lanes", 32'(obs_lanes), 32'(it.lanes));
          if (it.wr) begin
            chk(obs_bus == it.bus && obs_oe, "R7/R3", "write bus", 32'(obs_bus), 32'(it.bus));
            chk(we_run == EXP_WP, "R3", "write pulse clocks", 32'(we_run), 32'(EXP_WP));
            chk(oe_run == 0, "R3", "oe during write", 32'(oe_run), 0);
            chk(busy_run == EXP_WBUSY, "R4", "write busy clocks", 32'(busy_run), 32'(EXP_WBUSY));
          end else begin
            chk(rdata == it.rd, "R2/R8", "rdata", 32'(rdata), 32'(it.rd));
            chk(oe_run == EXP_RD, "R2", "read strobe clocks", 32'(oe_run), 32'(EXP_RD));
            chk(we_run == 0, "R2", "we during read", 32'(we_run), 0);
          end
        end
        busy_run = 0; we_run = 0; oe_run = 0; seen = 0;
      end
      prev_done = done;
    end
  end

  task automatic report;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", 1, 0);
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sram_cs_n == 2'b11 && sram_we_n == 2'b11 && sram_oe_n && !sram_dq_oe,
        "R1", "strobes in reset", {26'd0, sram_cs_n, sram_we_n, sram_oe_n, sram_dq_oe}, 32'h3e);
    chk(!done && !busy, "R1", "done/busy in reset", {30'd0, done, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(sram_cs_n == 2'b11 && !busy, "R1", "idle after reset", 32'(sram_cs_n), 3);

    // R2 word reads of seeded content
    do_req(0, 0, 18'h00012, 16'h0);
    do_req(0, 0, 18'h000F0, 16'h0);
    // R3 R4 word write then read back, R5 turnaround
    do_req(1, 0, 18'h00020, 16'hBEEF);
    do_req(0, 0, 18'h00020, 16'h0);
    // R9 top address bit ignored in word mode
    do_req(1, 0, 18'h20031, 16'h1234);
    do_req(0, 0, 18'h00031, 16'h0);
    // R6 R7 byte writes to each half
    do_req(1, 1, {10'h0, 7'h40, 1'b0}, 16'hFF5A);
    do_req(1, 1, {10'h0, 7'h41, 1'b1}, 16'h00C7);
    // R8 byte reads of each half
    do_req(0, 1, {10'h0, 7'h40, 1'b0}, 16'h0);
    do_req(0, 1, {10'h0, 7'h40, 1'b1}, 16'h0);
    do_req(0, 1, {10'h0, 7'h41, 1'b1}, 16'h0);
    do_req(0, 0, 18'h00041, 16'h0);
    // R11 requests while busy are ignored
    do_req(1, 0, 18'h00055, 16'hA0A0);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 18'h00066; req_wdata = 16'h6666;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    do_req(0, 0, 18'h00066, 16'h0);
    do_req(0, 0, 18'h00055, 16'h0);
    // drain
    @(negedge clk);
    while (busy || sbq.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    chk(sbq.size() == 0, "R11", "queue empty at end", 32'(sbq.size()), 0);
    report();
  end

endmodule